// File: doc/BRIEF.md
# Task Register with Hidden Descriptor Cache

This block keeps the identity of the running task. A 16-bit selector forms the part that software can read. Beside it, a hidden cache holds the task segment's 32-bit base, its 16-bit limit and its attribute bits. The address logic reads the cache directly through read-only outputs, so it can form task-segment addresses without a new descriptor fetch.

Three requests reach the register.

- **Explicit load.** It carries a selector, the descriptor already fetched for that selector, and the requester's privilege level. The load is honoured only at privilege level 0, and only for a selector that names the global table.
- **Implicit update.** It comes from the task-switch logic. It rewrites every field with no privilege check, and it takes precedence over an explicit load in the same cycle.
- **Store request.** It returns the selector alone, one cycle later, at any privilege level.

A rejected load changes nothing. It raises a one-cycle fault with an error code derived from the offending selector.

Top module: `task_reg_cache`

## Requirements
- R1: After reset the selector and base are 0, the limit is FFFFh, the attributes are 0, and `fault` and `rd_valid` are low.
- R2: An explicit load with `ld_cpl` = 0 and selector bit 2 (table indicator) = 0, and with no implicit update in the same cycle, writes the selector, base, limit and attributes. The new values are visible on the cycle after the request, and `fault` stays low.
- R3: An explicit load with `ld_cpl` not equal to 0 and no implicit update leaves all four fields unchanged. On the next cycle `fault` is high and `fault_code` equals `ld_sel` with bits 1:0 cleared.
- R4: An explicit load whose selector has bit 2 = 1 (local table) and no implicit update is rejected at any privilege level. It leaves the fields unchanged and gives the same fault and code as in R3.
- R5: An implicit update writes all four fields on the next cycle whatever the privilege level, and never raises `fault`.
- R6: When an explicit load and an implicit update arrive in the same cycle, the fields take the implicit update's values, the load is dropped, and no fault is raised even if the load was illegal.
- R7: A store request makes `rd_valid` high on the next cycle. `rd_sel` then carries the selector as it stood in the request cycle, before any update made in that same cycle. Without a request, `rd_valid` is low and `rd_sel` is 0.
- R8: In a cycle with neither a load nor an implicit update, all cached fields hold. `fault` is high for exactly one cycle per rejected load and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Explicit load request |
| ld_cpl | input | 2 | Privilege level of the load requester |
| ld_sel | input | 16 | Selector to load |
| ld_base | input | 32 | Descriptor base fetched for `ld_sel` |
| ld_limit | input | 16 | Descriptor limit fetched for `ld_sel` |
| ld_attr | input | 8 | Descriptor attribute bits |
| sw_upd | input | 1 | Implicit update from task-switch logic |
| sw_sel | input | 16 | New task selector |
| sw_base | input | 32 | New task segment base |
| sw_limit | input | 16 | New task segment limit |
| sw_attr | input | 8 | New task descriptor attributes |
| rd_req | input | 1 | Store (read selector) request |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_sel | output | 16 | Returned selector |
| tss_base | output | 32 | Cached base, read-only |
| tss_limit | output | 16 | Cached limit, read-only |
| tss_attr | output | 8 | Cached attributes, read-only |
| fault | output | 1 | One-cycle fault pulse for a rejected load |
| fault_code | output | 16 | Error code: offending selector with bits 1:0 cleared |

## Verification
The assertions assume that every control and data input is a known value, sampled on the rising edge, from the same clock domain. They also assume that a descriptor presented with a load belongs to the selector beside it, so the block never inspects the descriptor's contents. The stimulus changes inputs only on the falling edge and never drives unknown values. It mixes privileged and unprivileged loads, local-table selectors, simultaneous loads and updates, and reads landing in the same cycle as writes. A behavioural model then predicts every output on each cycle.

// File: rtl/task_reg_cache.sv
module task_reg_cache #(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 32,
  parameter int LIM_W  = 16,
  parameter int ATTR_W = 8,
  parameter int TI_BIT = 2,
  parameter logic [LIM_W-1:0] LIMIT_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [1:0]        ld_cpl,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic [ATTR_W-1:0] ld_attr,
  input  logic              sw_upd,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic [BASE_W-1:0] sw_base,
  input  logic [LIM_W-1:0]  sw_limit,
  input  logic [ATTR_W-1:0] sw_attr,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [BASE_W-1:0] tss_base,
  output logic [LIM_W-1:0]  tss_limit,
  output logic [ATTR_W-1:0] tss_attr,
  output logic              fault,
  output logic [SEL_W-1:0]  fault_code
);

  localparam logic [SEL_W-1:0] RPL_MASK = {{(SEL_W-2){1'b1}}, 2'b00};

  logic [SEL_W-1:0] sel_q;
  logic             ld_live, ld_ok, ld_bad;

  assign ld_live = ld_req & ~sw_upd;
  assign ld_ok   = ld_live & (ld_cpl == 2'd0) & ~ld_sel[TI_BIT];
  assign ld_bad  = ld_live & ~ld_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      tss_base  <= '0;
      tss_limit <= LIMIT_RST;
      tss_attr  <= '0;
    end else if (sw_upd) begin
      sel_q     <= sw_sel;
      tss_base  <= sw_base;
      tss_limit <= sw_limit;
      tss_attr  <= sw_attr;
    end else if (ld_ok) begin
      sel_q     <= ld_sel;
      tss_base  <= ld_base;
      tss_limit <= ld_limit;
      tss_attr  <= ld_attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      fault      <= ld_bad;
      fault_code <= ld_bad ? (ld_sel & RPL_MASK) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_sel   <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_sel   <= rd_req ? sel_q : '0;
    end
  end

  p_load_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !sw_upd && ld_cpl == 2'd0 && !ld_sel[TI_BIT]) |=>
      (tss_base == $past(ld_base) && tss_limit == $past(ld_limit) && !fault));

  p_cpl_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !sw_upd && ld_cpl != 2'd0) |=>
      (fault && $stable(tss_base) && $stable(tss_limit) && $stable(tss_attr)));

  p_local_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !sw_upd && ld_sel[TI_BIT]) |=>
      (fault && fault_code[1:0] == 2'b00 && $stable(tss_base)));

  p_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (tss_base == $past(sw_base) && tss_attr == $past(sw_attr) && !fault));

  p_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd && ld_req) |=> (tss_limit == $past(sw_limit) && !fault));

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_req && !sw_upd) |=>
      ($stable(tss_base) && $stable(tss_limit) && $stable(tss_attr) && !fault));

endmodule

// File: tb/sim_task_reg_cache.sv
module sim_task_reg_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0, sw_upd = 1'b0, rd_req = 1'b0;
  logic [1:0]  ld_cpl = '0;
  logic [15:0] ld_sel = '0, ld_limit = '0, sw_sel = '0, sw_limit = '0;
  logic [31:0] ld_base = '0, sw_base = '0;
  logic [7:0]  ld_attr = '0, sw_attr = '0;
  logic        rd_valid, fault;
  logic [15:0] rd_sel, tss_limit, fault_code;
  logic [31:0] tss_base;
  logic [7:0]  tss_attr;

  int n_cmp = 0, n_bad = 0;
  logic        done = 1'b0;

  logic [15:0] m_sel = 16'h0, m_limit = 16'hFFFF, m_rds = 16'h0, m_fc = 16'h0;
  logic [31:0] m_base = 32'h0;
  logic [7:0]  m_attr = 8'h0;
  logic        m_rdv = 1'b0, m_fault = 1'b0;
  string       tag = "R1";

  always #2.5 clk = ~clk;

  task_reg_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_cpl(ld_cpl), .ld_sel(ld_sel), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_attr(ld_attr),
    .sw_upd(sw_upd), .sw_sel(sw_sel), .sw_base(sw_base), .sw_limit(sw_limit),
    .sw_attr(sw_attr), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .tss_base(tss_base),
    .tss_limit(tss_limit), .tss_attr(tss_attr), .fault(fault), .fault_code(fault_code)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, "base", tss_base, m_base);
    cmp(req, "limit", {16'h0, tss_limit}, {16'h0, m_limit});
    cmp(req, "attr", {24'h0, tss_attr}, {24'h0, m_attr});
    cmp(req, "fault", {31'h0, fault}, {31'h0, m_fault});
    if (m_fault) cmp(req, "fault_code", {16'h0, fault_code}, {16'h0, m_fc});
    cmp("R7", "rd_valid", {31'h0, rd_valid}, {31'h0, m_rdv});
    cmp("R7", "rd_sel", {16'h0, rd_sel}, {16'h0, m_rds});
  endtask

  // behavioural reference for one rising edge
  task automatic model_step();
    m_rdv = rd_req;
    m_rds = rd_req ? m_sel : 16'h0;
    m_fault = 1'b0;
    if (sw_upd) begin
      tag = ld_req ? "R6" : "R5";
      m_sel = sw_sel; m_base = sw_base; m_limit = sw_limit; m_attr = sw_attr;
    end else if (ld_req) begin
      if (ld_cpl != 0 || ld_sel[2]) begin
        tag = (ld_cpl != 0) ? "R3" : "R4";
        m_fault = 1'b1;
        m_fc = {ld_sel[15:2], 2'b00};
      end else begin
        tag = "R2";
        m_sel = ld_sel; m_base = ld_base; m_limit = ld_limit; m_attr = ld_attr;
      end
    end else begin
      tag = "R8";
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
    ld_req = 1'b0; sw_upd = 1'b0; rd_req = 1'b0;
  endtask

  task automatic drive_ld(input logic [1:0] cpl, input logic [15:0] s);
    ld_req = 1'b1; ld_cpl = cpl; ld_sel = s;
    ld_base = $urandom; ld_limit = 16'($urandom); ld_attr = 8'($urandom);
  endtask

  task automatic drive_sw(input logic [15:0] s);
    sw_upd = 1'b1; sw_sel = s;
    sw_base = $urandom; sw_limit = 16'($urandom); sw_attr = 8'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rd_req = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    cycle();
    // R2 privileged global load, then read back
    drive_ld(2'd0, 16'h0028); cycle();
    rd_req = 1'b1; cycle();
    // R3 unprivileged
    drive_ld(2'd3, 16'h0033); cycle();
    cycle();
    // R4 local-table selector at level 0
    drive_ld(2'd0, 16'h0047); cycle();
    // R5 implicit update
    drive_sw(16'h0050); rd_req = 1'b1; cycle();
    rd_req = 1'b1; cycle();
    // R6 clash with illegal and legal load
    drive_sw(16'h0060); drive_ld(2'd2, 16'h0064); cycle();
    drive_sw(16'h0070); drive_ld(2'd0, 16'h0078); rd_req = 1'b1; cycle();
    // back-to-back faults
    drive_ld(2'd1, 16'hFFFF); cycle();
    drive_ld(2'd0, 16'hFFFC); cycle();
    cycle();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) == 0) drive_ld(2'($urandom), 16'($urandom));
      if ($urandom_range(0, 4) == 0) drive_sw(16'($urandom));
      rd_req = ($urandom_range(0, 2) == 0);
      cycle();
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule